// File: doc/BRIEF.md
# Sequential Target-Value Comparator

This block watches a free-running count value that comes from outside and compares it with a small table of programmed target values. Only one table entry is live at a time. When the count equals that entry's target, the entry's bit pattern is written into a result word and the selection steps to the next entry. After the last valid entry has matched, the selection goes back to entry 0 and the sequence starts over.

Software, or a sequencer, loads the table through a write port: an entry index, a target value and a pattern. It also sets how many entries are valid, and that number may be smaller than the table depth. A four-bit pattern lands in bits 11 down to 8 of a 16-bit result word, and those bits also drive four external output lines. The counter that produces the count is not part of this block. Neither is any interrupt logic.

A synchronous clear empties the result word and points the selection back at entry 0. Any write to the table or to the valid-entry count also restarts the sequence at entry 0.

Top module: `tgt_seq_cmp`

## Requirements
- R1: After the asynchronous active-low reset, `result` is 0, `ext_out` is 0 and `cur_idx` is 0.
- R2: Only the entry selected by `cur_idx` is compared. A count equal to the target of any other entry changes neither `cur_idx` nor `result`.
- R3: When `enable` is 1 and `count_in` equals the selected target at a rising clock edge, `result` shows that entry's pattern in bits 11..8 from that edge on. All other bits of `result` are 0, and `ext_out[k]` equals `result[8+k]`.
- R4: A match moves `cur_idx` from i to i+1 on the same edge.
- R5: A match on entry (valid count − 1) sets `cur_idx` to 0, and the sequence then repeats.
- R6: If the count stays on a matching value for several cycles, it causes one match only. The same value can match again only after the count has left that value.
- R7: Between matches, `result` holds its value.
- R8: A table write (`tbl_we`) or a valid-count write (`nv_we`) sets `cur_idx` to 0 on that edge and leaves `result` unchanged. A match in that same cycle is dropped.
- R9: `clear` set to 1 makes `result` 0 and `cur_idx` 0 on the next edge.
- R10: While `enable` is 0, or while the valid count is 0, no match takes place.
- R11: A valid count written above DEPTH (8) is taken as DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enable | input | 1 | Allows matches to take place |
| clear | input | 1 | Synchronous clear of the result word and the selection |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | 3 | Entry index to write |
| tbl_target | input | 32 | Target value to write |
| tbl_pattern | input | 4 | Pattern to write |
| nv_we | input | 1 | Valid-count write strobe |
| nv_value | input | 4 | Number of valid entries, saturated at DEPTH |
| count_in | input | 32 | Count value under comparison |
| result | output | 16 | Result word; the pattern sits in bits 11..8 |
| ext_out | output | 4 | External outputs 1..4, driven from result bits 8..11 |
| cur_idx | output | 3 | Currently selected entry |

## Verification
The bound checker tests, on every cycle, the properties that only involve nearby cycles:
- every match agrees with the target of the selected entry;
- the selection only steps by one or returns to zero;
- a count that stays put cannot match twice in a row;
- the result word only changes after a match or a clear;
- writes and clears restart the selection;
- a disabled block never matches.

Some behaviour can only be shown by the bench's scenarios, because it depends on what the table holds and on the order of the sequence:
- the wrap after exactly the programmed number of entries;
- the saturation of an oversized valid count;
- targets of non-selected entries being ignored;
- a held value matching again once the count leaves it and comes back.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int unsigned DEF_DEPTH   = 8;
  localparam int unsigned DEF_CNT_W   = 32;
  localparam int unsigned DEF_PAT_W   = 4;
  localparam int unsigned DEF_RES_W   = 16;
  localparam int unsigned DEF_PAT_LSB = 8;

  // width needed to hold a count of 0..depth valid entries
  function automatic int unsigned nv_width(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/tsc_table.sv
module tsc_table #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PAT_W = 4,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CNT_W-1:0] wr_target,
  input  logic [PAT_W-1:0] wr_pattern,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_target,
  output logic [PAT_W-1:0] rd_pattern
);
  logic [CNT_W-1:0] tgt_q [DEPTH];
  logic [PAT_W-1:0] pat_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic ent_we;
    assign ent_we = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tgt_q[e] <= '0;
        pat_q[e] <= '0;
      end else if (ent_we) begin
        tgt_q[e] <= wr_target;
        pat_q[e] <= wr_pattern;
      end
    end
  end

  assign rd_target  = tgt_q[rd_idx];
  assign rd_pattern = pat_q[rd_idx];
endmodule

// File: rtl/tsc_seq_ctrl.sv
module tsc_seq_ctrl #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned NV_W  = tsc_pkg::nv_width(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             clear,
  input  logic             restart,
  input  logic             nv_we,
  input  logic [NV_W-1:0]  nv_value,
  input  logic [CNT_W-1:0] count_in,
  input  logic [CNT_W-1:0] sel_target,
  output logic [IDX_W-1:0] cur_idx,
  output logic             hit
);
  logic [NV_W-1:0]  nv_q, nv_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             lock_q, lock_d;
  logic [CNT_W-1:0] lockv_q, lockv_d;
  logic             blocked, at_last;

  // a value that already matched stays blocked until the count moves away
  assign blocked = lock_q && (count_in == lockv_q);
  assign hit     = enable && !clear && !restart && (nv_q != '0)
                   && (count_in == sel_target) && !blocked;
  assign at_last = (NV_W'(idx_q) == nv_q - NV_W'(1));

  always_comb begin
    nv_d = nv_q;
    if (nv_we) begin
      nv_d = (nv_value > NV_W'(DEPTH)) ? NV_W'(DEPTH) : nv_value;
    end
  end

  always_comb begin
    idx_d   = idx_q;
    lock_d  = lock_q;
    lockv_d = lockv_q;
    if (clear || restart) begin
      idx_d  = '0;
      lock_d = 1'b0;
    end else if (hit) begin
      idx_d   = at_last ? '0 : idx_q + IDX_W'(1);
      lock_d  = 1'b1;
      lockv_d = count_in;
    end else if (lock_q && !blocked) begin
      lock_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q    <= '0;
      idx_q   <= '0;
      lock_q  <= 1'b0;
      lockv_q <= '0;
    end else begin
      nv_q    <= nv_d;
      idx_q   <= idx_d;
      lock_q  <= lock_d;
      lockv_q <= lockv_d;
    end
  end

  assign cur_idx = idx_q;
endmodule

// File: rtl/tsc_result.sv
module tsc_result #(
  parameter int unsigned PAT_W   = 4,
  parameter int unsigned RES_W   = 16,
  parameter int unsigned PAT_LSB = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [PAT_W-1:0] pattern,
  output logic [RES_W-1:0] result
);
  logic [RES_W-1:0] res_q, res_d;

  always_comb begin
    res_d = res_q;
    if (clear) begin
      res_d = '0;
    end else if (load) begin
      res_d = '0;
      res_d[PAT_LSB +: PAT_W] = pattern;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;
  end

  assign result = res_q;
endmodule

// File: rtl/tgt_seq_cmp.sv
module tgt_seq_cmp #(
  parameter int unsigned DEPTH   = tsc_pkg::DEF_DEPTH,
  parameter int unsigned CNT_W   = tsc_pkg::DEF_CNT_W,
  parameter int unsigned PAT_W   = tsc_pkg::DEF_PAT_W,
  parameter int unsigned RES_W   = tsc_pkg::DEF_RES_W,
  parameter int unsigned PAT_LSB = tsc_pkg::DEF_PAT_LSB,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned NV_W   = tsc_pkg::nv_width(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             clear,
  input  logic             tbl_we,
  input  logic [IDX_W-1:0] tbl_idx,
  input  logic [CNT_W-1:0] tbl_target,
  input  logic [PAT_W-1:0] tbl_pattern,
  input  logic             nv_we,
  input  logic [NV_W-1:0]  nv_value,
  input  logic [CNT_W-1:0] count_in,
  output logic [RES_W-1:0] result,
  output logic [PAT_W-1:0] ext_out,
  output logic [IDX_W-1:0] cur_idx
);
  logic [CNT_W-1:0] sel_target;
  logic [PAT_W-1:0] sel_pattern;
  logic             hit;
  logic             restart;

  assign restart = tbl_we || nv_we;

  tsc_table #(.DEPTH(DEPTH), .CNT_W(CNT_W), .PAT_W(PAT_W)) table_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (tbl_we),
    .wr_idx     (tbl_idx),
    .wr_target  (tbl_target),
    .wr_pattern (tbl_pattern),
    .rd_idx     (cur_idx),
    .rd_target  (sel_target),
    .rd_pattern (sel_pattern)
  );

  tsc_seq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .clear      (clear),
    .restart    (restart),
    .nv_we      (nv_we),
    .nv_value   (nv_value),
    .count_in   (count_in),
    .sel_target (sel_target),
    .cur_idx    (cur_idx),
    .hit        (hit)
  );

  tsc_result #(.PAT_W(PAT_W), .RES_W(RES_W), .PAT_LSB(PAT_LSB)) result_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .load    (hit),
    .pattern (sel_pattern),
    .result  (result)
  );

  assign ext_out = result[PAT_LSB +: PAT_W];
endmodule

// File: rtl/tgt_seq_cmp_chk.sv
module tgt_seq_cmp_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 32,
  parameter int unsigned RES_W = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             clear,
  input logic             tbl_we,
  input logic             nv_we,
  input logic             hit,
  input logic [CNT_W-1:0] count_in,
  input logic [CNT_W-1:0] sel_target,
  input logic [IDX_W-1:0] cur_idx,
  input logic [RES_W-1:0] result
);
  // R2: a match always concerns the selected entry's target
  p_hit_on_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (count_in == sel_target));

  // R4, R5: the selection steps by one or returns to entry 0
  p_step_or_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_idx) |-> (cur_idx == '0) || (cur_idx == IDX_W'($past(cur_idx) + 1'b1)));

  // R6: an unchanged count cannot match on two consecutive edges
  p_single_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !(hit && (count_in == $past(count_in))));

  // R7: the result word moves only after a match or a clear
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> ($past(hit) || $past(clear)));

  // R8: writes restart the sequence
  p_write_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we || nv_we) |=> (cur_idx == '0));

  // R9: clear empties the result and the selection
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (result == '0) && (cur_idx == '0));

  // R10: no match while disabled
  p_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !hit);
endmodule

bind tgt_seq_cmp tgt_seq_cmp_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .RES_W(RES_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .clear      (clear),
  .tbl_we     (tbl_we),
  .nv_we      (nv_we),
  .hit        (hit),
  .count_in   (count_in),
  .sel_target (sel_target),
  .cur_idx    (cur_idx),
  .result     (result)
);

// File: tb/tgt_seq_cmp_tb_top.sv
module tgt_seq_cmp_tb_top;
  localparam int unsigned DEPTH = 8;
  localparam int unsigned IDX_W = 3;
  localparam int unsigned NV_W  = 4;

  typedef struct {
    int          idx;
    logic [15:0] res;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        clear = 1'b0;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_idx = '0;
  logic [31:0] tbl_target = '0;
  logic [3:0]  tbl_pattern = '0;
  logic        nv_we = 1'b0;
  logic [3:0]  nv_value = '0;
  logic [31:0] count_in = '0;
  logic [15:0] result;
  logic [3:0]  ext_out;
  logic [2:0]  cur_idx;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  exp_t sb_q[$];

  // reference model state
  logic [31:0] m_tgt [DEPTH];
  logic [3:0]  m_pat [DEPTH];
  int          m_nv = 0;
  int          m_idx = 0;
  logic [15:0] m_res = '0;
  bit          m_lock = 1'b0;
  logic [31:0] m_lockv = '0;

  always #2.5 clk = ~clk;

  tgt_seq_cmp dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_target(tbl_target),
    .tbl_pattern(tbl_pattern), .nv_we(nv_we), .nv_value(nv_value),
    .count_in(count_in), .result(result), .ext_out(ext_out), .cur_idx(cur_idx)
  );

  task automatic check(input string tag, input int a_idx, input logic [15:0] a_res,
                       input logic [3:0] a_ext, input int e_idx, input logic [15:0] e_res);
    n_checks++;
    if (a_idx != e_idx || a_res != e_res || a_ext != e_res[11:8]) begin
      n_fail++;
      $display("FAIL %s: idx=%0d result=%h ext=%h, expected idx=%0d result=%h ext=%h",
               tag, a_idx, a_res, a_ext, e_idx, e_res, e_res[11:8]);
    end
  endtask

  // monitor: compares each cycle's outcome just after the edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, int'(cur_idx), result, ext_out, e.idx, e.res);
    end
  end

  // driver: one clock cycle with the given inputs, expected outcome pushed
  task automatic cyc(input string tag, input logic [31:0] cnt, input logic en,
                     input logic clr, input logic twe, input int tidx,
                     input logic [31:0] ttgt, input logic [3:0] tpat,
                     input logic nwe, input int nval);
    bit hit;
    bit rst_seq;
    exp_t e;
    @(negedge clk);
    count_in = cnt; enable = en; clear = clr;
    tbl_we = twe; tbl_idx = IDX_W'(tidx); tbl_target = ttgt; tbl_pattern = tpat;
    nv_we = nwe; nv_value = NV_W'(nval);
    rst_seq = twe || nwe;
    hit = en && !clr && !rst_seq && (m_nv != 0) && (cnt == m_tgt[m_idx])
          && !(m_lock && cnt == m_lockv);
    if (clr || rst_seq) begin
      m_idx = 0; m_lock = 1'b0;
      if (clr) m_res = '0;
    end else if (hit) begin
      m_res = {4'h0, m_pat[m_idx], 8'h00};
      m_idx = (m_idx == m_nv - 1) ? 0 : m_idx + 1;
      m_lock = 1'b1; m_lockv = cnt;
    end else if (m_lock && cnt != m_lockv) begin
      m_lock = 1'b0;
    end
    if (twe) begin m_tgt[tidx] = ttgt; m_pat[tidx] = tpat; end
    if (nwe) m_nv = (nval > DEPTH) ? DEPTH : nval;
    e.idx = m_idx; e.res = m_res; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic run(input string tag, input logic [31:0] cnt, input logic en);
    cyc(tag, cnt, en, 1'b0, 1'b0, 0, '0, '0, 1'b0, 0);
  endtask

  task automatic wr(input int i, input logic [31:0] t, input logic [3:0] p);
    cyc("R8 table write", count_in, 1'b1, 1'b0, 1'b1, i, t, p, 1'b0, 0);
  endtask

  task automatic set_nv(input string tag, input int n);
    cyc(tag, count_in, 1'b1, 1'b0, 1'b0, 0, '0, '0, 1'b1, n);
  endtask

  task automatic ramp(input string tag, input int lo, input int hi);
    for (int c = lo; c <= hi; c++) run(tag, 32'(c), 1'b1);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_tgt[i] = '0; m_pat[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", int'(cur_idx), result, ext_out, 0, 16'h0000);
    rst_n = 1'b1;

    // main table: five targets, patterns chosen to be distinct
    wr(0, 10, 4'h1); wr(1, 20, 4'h2); wr(2, 30, 4'h4); wr(3, 40, 4'h8); wr(4, 50, 4'h3);
    wr(5, 60, 4'hF); wr(6, 70, 4'hE); wr(7, 80, 4'hD);
    set_nv("R8 count write", 5);

    // R10: disabled, count on entry 0 target
    run("R10 disabled", 32'd10, 1'b0);
    run("R10 disabled", 32'd11, 1'b0);
    // R2: other entries' targets ignored while entry 0 selected
    run("R2 ignore entry2", 32'd30, 1'b1);
    run("R2 ignore entry4", 32'd50, 1'b1);
    // R3, R4, R5, R7: two full passes
    ramp("R3 R4 R7 pass1", 0, 55);
    ramp("R5 wrap pass2", 0, 55);

    // R8: write in mid-sequence restarts and keeps result
    ramp("R4 advance", 0, 25);
    wr(2, 30, 4'h4);
    run("R8 after restart", 32'd20, 1'b1);
    run("R8 entry0 again", 32'd10, 1'b1);

    // R9: clear mid-sequence
    ramp("R4 advance", 11, 35);
    cyc("R9 clear", 32'd40, 1'b1, 1'b1, 1'b0, 0, '0, '0, 1'b0, 0);
    run("R9 after clear", 32'd40, 1'b1);

    // R6: two entries with the same target; a held count matches once
    wr(0, 7, 4'h5); wr(1, 7, 4'h9);
    set_nv("R8 count write", 2);
    for (int k = 0; k < 4; k++) run("R6 held value", 32'd7, 1'b1);
    run("R6 leave", 32'd8, 1'b1);
    run("R6 return", 32'd7, 1'b1);
    run("R6 held again", 32'd7, 1'b1);

    // R10: zero valid entries
    set_nv("R10 zero count", 0);
    run("R10 zero count", 32'd8, 1'b1);
    run("R10 zero count", 32'd7, 1'b1);

    // R11: oversized count saturates to all eight entries
    wr(0, 10, 4'h1); wr(1, 20, 4'h2);
    set_nv("R11 saturate", 15);
    ramp("R11 eight entries", 0, 85);
    ramp("R11 wrap after eight", 0, 15);

    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done && sb_q.size() == 0);
      begin
        #(200000 * 5);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule